// File: doc/BRIEF.md
# Slave Port Arbiter for a Six-Master Bus Matrix

This block sits in front of a single slave port of a multi-layer bus matrix and decides which of six masters owns that port. It offers two policies. The first is fixed priority, which uses a 2-bit priority level per master. The second is round robin, which has a choice of what the port does when nobody is asking for it: it can park nowhere, park on the master that used it last, or park on one configured master.

Ownership changes only at transfer boundaries. A boundary is one of these:
- the port is idle and its owner has stopped requesting;
- the final beat of a burst has completed;
- a programmable slot budget of beats has been used up.

The slot budget is the only thing that bounds a burst of undefined length. A budget of zero lets a burst run until its final beat. The surrounding matrix uses the one-hot grant to steer its address and data multiplexers, and uses the index output for tagging.

Top module: `slave_port_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set. `gnt_idx_o` is the position of that bit, and is 0 when no bit is set. After reset no master is granted.
- R2: With `cfg_rr_i`=0 (fixed priority), a decision goes to the requesting master whose priority field is largest. Master i's field is `cfg_prio_i[2i+1:2i]`. On equal fields the lower index wins. With no request, nobody is granted.
- R3: With `cfg_rr_i`=1 (round robin), a decision goes to the first requester found by searching upward from the master after the last request-winning master. The search wraps from 5 to 0. After reset the search starts at master 0.
- R4: In round robin with `cfg_dflt_mode_i`=2'b00 or 2'b11 (no default), a decision made with no request leaves the port ungranted. This shows on the clock edge after the owner drops its request on an idle port.
- R5: In round robin with `cfg_dflt_mode_i`=2'b01 (last accessed), a decision made with no request grants the last master that won by request.
- R6: In round robin with `cfg_dflt_mode_i`=2'b10 (fixed default), a decision made with no request grants master `cfg_dflt_mst_i`.
- R7: A burst begins when `burst_start_i` is seen on an idle port that has an owner. Until it ends, the grant outputs do not change. Beats are counted only while a burst is in progress.
- R8: At burst start, the slot counter loads `cfg_slot_lim_i`. The counter decrements on each beat. The beat that brings it to zero ends the burst and triggers a new decision, which takes effect on that clock edge.
- R9: A slot limit of 0 never breaks a burst. The burst holds the port until a beat arrives with `last_beat_i`=1.
- R10: On an idle port, an owner that keeps requesting keeps the grant, even when other masters are requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 6 | Request line, one per master |
| burst_start_i | input | 1 | Granted master begins a burst this cycle |
| beat_done_i | input | 1 | One data beat completes this cycle |
| last_beat_i | input | 1 | The completing beat is the final one of the burst |
| cfg_rr_i | input | 1 | Policy: 0 fixed priority, 1 round robin |
| cfg_dflt_mode_i | input | 2 | Round-robin parking: 00 none, 01 last, 10 fixed, 11 none |
| cfg_dflt_mst_i | input | 3 | Parking master for fixed default (0..5) |
| cfg_prio_i | input | 12 | Priority fields, 2 bits per master |
| cfg_slot_lim_i | input | 8 | Beats per slot; 0 disables breaking |
| gnt_o | output | 6 | One-hot grant |
| gnt_idx_o | output | 3 | Index of the granted master |

## Verification
The embedded assertions check the following on every cycle:
- the grant is one-hot or empty;
- the grant is frozen inside a burst that is not ending;
- a fixed-priority decision lands on a requester;
- the no-default and fixed-default parking outcomes are correct;
- the slot counter loads correctly.

Some behaviour can only be shown by the bench's scenarios, because each depends on a history of several decisions:
- the rotating round-robin pointer and its wrap from 5 to 0;
- the tie-break toward lower indices;
- parking on the last accessed master;
- a break exactly on the limit-th beat;
- an unbroken burst of undefined length with a zero limit.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    DFLT_NONE  = 2'b00,
    DFLT_LAST  = 2'b01,
    DFLT_FIXED = 2'b10,
    DFLT_NONE2 = 2'b11
  } dflt_mode_e;
endpackage

// File: rtl/arb_fixed_prio.sv
module arb_fixed_prio #(
  parameter int unsigned N_MST  = 6,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  output logic                    win_vld_o,
  output logic [IDX_W-1:0]        win_idx_o
);
  logic [PRIO_W-1:0] best;

  // strict '>' keeps the lowest index on ties
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    best      = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (req_i[i] && (!win_vld_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
        best      = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/arb_round_robin.sv
module arb_round_robin #(
  parameter int unsigned N_MST = 6,
  localparam int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o
);
  int j;

  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    j         = 0;
    for (int k = 1; k <= N_MST; k++) begin
      j = (int'(last_i) + k) % N_MST;
      if (!win_vld_o && req_i[j]) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] lim_i,
  input  logic              beat_i,
  output logic              expire_o
);
  logic [SLOT_W-1:0] cnt_q;

  // loaded zero never reaches one: breaking disabled
  assign expire_o = beat_i && (cnt_q == SLOT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= lim_i;
    else if (beat_i && cnt_q != '0)    cnt_q <= cnt_q - SLOT_W'(1);
  end

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(lim_i));
  a_r9_zero_never_expires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && lim_i == '0) |=> !expire_o);
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N_MST  = 6,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned SLOT_W = 8,
  localparam int unsigned IDX_W = $clog2(N_MST)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST-1:0]        req_i,
  input  logic                    burst_start_i,
  input  logic                    beat_done_i,
  input  logic                    last_beat_i,
  input  logic                    cfg_rr_i,
  input  logic [1:0]              cfg_dflt_mode_i,
  input  logic [IDX_W-1:0]        cfg_dflt_mst_i,
  input  logic [N_MST*PRIO_W-1:0] cfg_prio_i,
  input  logic [SLOT_W-1:0]       cfg_slot_lim_i,
  output logic [N_MST-1:0]        gnt_o,
  output logic [IDX_W-1:0]        gnt_idx_o
);
  logic             own_vld_q, have_last_q, busy_q;
  logic [IDX_W-1:0] own_q, last_q;
  logic             fp_vld, rr_vld;
  logic [IDX_W-1:0] fp_idx, rr_idx;
  logic             start_go, beat, expire, end_evt, own_req, arb_en;
  logic             nxt_vld, take;
  logic [IDX_W-1:0] nxt_idx;
  dflt_mode_e       mode;

  assign mode = dflt_mode_e'(cfg_dflt_mode_i);

  arb_fixed_prio #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_fp (
    .req_i(req_i), .prio_i(cfg_prio_i), .win_vld_o(fp_vld), .win_idx_o(fp_idx)
  );

  arb_round_robin #(.N_MST(N_MST)) u_rr (
    .req_i(req_i), .last_i(last_q), .win_vld_o(rr_vld), .win_idx_o(rr_idx)
  );

  assign start_go = !busy_q && burst_start_i && own_vld_q;
  assign beat     = busy_q && beat_done_i;

  slot_counter #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_go), .lim_i(cfg_slot_lim_i),
    .beat_i(beat), .expire_o(expire)
  );

  assign end_evt = beat && (last_beat_i || expire);
  assign own_req = own_vld_q && req_i[own_q];
  // idle owner that still requests is left parked
  assign arb_en  = (!busy_q && !start_go && !own_req) || end_evt;

  always_comb begin
    nxt_vld = own_vld_q;
    nxt_idx = own_q;
    take    = 1'b0;
    if (arb_en) begin
      if (cfg_rr_i) begin
        if (rr_vld) begin
          nxt_vld = 1'b1; nxt_idx = rr_idx; take = 1'b1;
        end else begin
          unique case (mode)
            DFLT_LAST:  begin nxt_vld = have_last_q; nxt_idx = have_last_q ? last_q : '0; end
            DFLT_FIXED: begin nxt_vld = 1'b1;        nxt_idx = cfg_dflt_mst_i;            end
            default:    begin nxt_vld = 1'b0;        nxt_idx = '0;                        end
          endcase
        end
      end else begin
        nxt_vld = fp_vld;
        nxt_idx = fp_vld ? fp_idx : '0;
        take    = fp_vld;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q   <= 1'b0;
      own_q       <= '0;
      last_q      <= IDX_W'(N_MST-1);
      have_last_q <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      own_vld_q <= nxt_vld;
      own_q     <= nxt_idx;
      if (take) begin
        last_q      <= nxt_idx;
        have_last_q <= 1'b1;
      end
      if (start_go)     busy_q <= 1'b1;
      else if (end_evt) busy_q <= 1'b0;
    end
  end

  always_comb begin
    gnt_o = '0;
    if (own_vld_q) gnt_o[own_q] = 1'b1;
  end
  assign gnt_idx_o = own_q;

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r7_hold_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !end_evt) |=> ($stable(gnt_o) && $stable(gnt_idx_o)));
  a_r2_fp_to_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rr_i && arb_en && (req_i != '0)) |=> ((gnt_o & $past(req_i)) != '0));
  a_r4_park_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rr_i && !cfg_dflt_mode_i[0] && !cfg_dflt_mode_i[1] && arb_en && req_i == '0)
      |=> gnt_o == '0);
  a_r6_park_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rr_i && cfg_dflt_mode_i == 2'b10 && arb_en && req_i == '0)
      |=> (gnt_idx_o == $past(cfg_dflt_mst_i) && gnt_o != '0));
endmodule

// File: tb/slave_port_arbiter_bench.sv
`timescale 1ns/1ps
module slave_port_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  req = '0;
  logic        bs = 1'b0, bd = 1'b0, lb = 1'b0;
  logic        rr = 1'b0;
  logic [1:0]  dmode = 2'b00;
  logic [2:0]  dmst = 3'd0;
  logic [11:0] prio = '0;
  logic [7:0]  lim = '0;
  logic [5:0]  gnt;
  logic [2:0]  gidx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";

  // model state
  bit       m_vld, m_busy, m_have;
  int       m_own, m_last, m_cnt;

  always #2.5 clk = ~clk;

  slave_port_arbiter u_slave_port_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .burst_start_i(bs),
    .beat_done_i(bd), .last_beat_i(lb), .cfg_rr_i(rr), .cfg_dflt_mode_i(dmode),
    .cfg_dflt_mst_i(dmst), .cfg_prio_i(prio), .cfg_slot_lim_i(lim),
    .gnt_o(gnt), .gnt_idx_o(gidx)
  );

  function automatic int fp_pick(logic [5:0] r, logic [11:0] p);
    int w = -1; int b = -1;
    for (int i = 0; i < 6; i++)
      if (r[i] && int'(p[2*i +: 2]) > b) begin w = i; b = int'(p[2*i +: 2]); end
    return w;
  endfunction

  function automatic int rr_pick(logic [5:0] r, int last);
    for (int k = 1; k <= 6; k++)
      if (r[(last + k) % 6]) return (last + k) % 6;
    return -1;
  endfunction

  task automatic check(string t, logic [5:0] eg, logic [2:0] ei);
    n_chk++;
    if (gnt !== eg || gidx !== ei) begin
      n_fail++;
      $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d", t, gnt, gidx, eg, ei);
    end
  endtask

  task automatic check_lit(string t, bit v, int idx);
    check(t, v ? 6'(1 << idx) : 6'b0, v ? 3'(idx) : 3'd0);
  endtask

  task automatic model_check();
    check(tag, m_vld ? 6'(1 << m_own) : 6'b0, m_vld ? 3'(m_own) : 3'd0);
  endtask

  // drive at negedge, advance model, sample at next negedge
  task automatic cyc(logic [5:0] r, bit s, bit d, bit l);
    bit st, bt, ex, en, arb; int w;
    req = r; bs = s; bd = d; lb = l;
    st  = !m_busy && s && m_vld;
    bt  = m_busy && d;
    ex  = bt && m_cnt == 1;
    en  = bt && (l || ex);
    arb = (!m_busy && !st && !(m_vld && r[m_own])) || en;
    if (arb) begin
      w = rr ? rr_pick(r, m_last) : fp_pick(r, prio);
      if (w >= 0) begin
        m_vld = 1; m_own = w; m_last = w; m_have = 1;
      end else if (!rr) begin
        m_vld = 0; m_own = 0;
      end else if (dmode == 2'b01) begin
        m_vld = m_have; m_own = m_have ? m_last : 0;
      end else if (dmode == 2'b10) begin
        m_vld = 1; m_own = int'(dmst);
      end else begin
        m_vld = 0; m_own = 0;
      end
    end
    if (st) m_cnt = int'(lim);
    else if (bt && m_cnt != 0) m_cnt--;
    if (st) m_busy = 1; else if (en) m_busy = 0;
    @(posedge clk); @(negedge clk);
    model_check();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] rq;
    void'($urandom(32'h1234_abcd));
    m_vld = 0; m_busy = 0; m_have = 0; m_own = 0; m_last = 5; m_cnt = 0;
    repeat (3) @(negedge clk);
    check_lit("R1 reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(6'b0, 0, 0, 0);
    check_lit("R1 idle after reset", 0, 0);

    // R2 fixed priority, tie between 2 and 4 at level 3
    tag = "R2";
    prio = {2'd0, 2'd3, 2'd2, 2'd3, 2'd0, 2'd1};
    cyc(6'b010110, 0, 0, 0);  check_lit("R2 tie to lower index", 1, 2);
    cyc(6'b0, 0, 0, 0);       check_lit("R2 no request none", 0, 0);

    // R3 round robin with wrap
    tag = "R3"; rr = 1; dmode = 2'b00;
    cyc(6'b100001, 0, 0, 0);  check_lit("R3 search after 2", 1, 5);
    cyc(6'b100001, 1, 0, 0);
    cyc(6'b100001, 0, 1, 1);  check_lit("R3 wrap 5 to 0", 1, 0);
    cyc(6'b100001, 1, 0, 0);
    cyc(6'b100001, 0, 1, 1);  check_lit("R3 rotate to 5", 1, 5);

    tag = "R4";
    cyc(6'b0, 0, 0, 0);       check_lit("R4 park none", 0, 0);

    tag = "R5"; dmode = 2'b01;
    cyc(6'b001000, 0, 0, 0);  check_lit("R5 grant 3", 1, 3);
    cyc(6'b0, 0, 0, 0);       check_lit("R5 park last", 1, 3);
    cyc(6'b0, 0, 0, 0);       check_lit("R5 park last stays", 1, 3);

    tag = "R6"; dmode = 2'b10; dmst = 3'd4;
    cyc(6'b0, 0, 0, 0);       check_lit("R6 park fixed", 1, 4);

    // R8 slot limit 3 breaks on third beat
    tag = "R8"; lim = 8'd3;
    cyc(6'b000011, 0, 0, 0);  check_lit("R8 grant 0", 1, 0);
    cyc(6'b000011, 1, 0, 0);
    cyc(6'b000011, 0, 1, 0);  check_lit("R7 hold beat 1", 1, 0);
    cyc(6'b000011, 0, 1, 0);  check_lit("R7 hold beat 2", 1, 0);
    cyc(6'b000011, 0, 1, 0);  check_lit("R8 break at limit", 1, 1);

    tag = "R9"; lim = 8'd0;
    cyc(6'b000011, 1, 0, 0);
    for (int i = 0; i < 10; i++) begin
      cyc(6'b000011, 0, 1, 0); check_lit("R9 unbroken burst", 1, 1);
    end
    cyc(6'b000011, 0, 1, 1);  check_lit("R9 end on last beat", 1, 0);

    tag = "R10";
    for (int i = 0; i < 5; i++) begin
      cyc(6'b000011, 0, 0, 0); check_lit("R10 idle owner keeps grant", 1, 0);
    end

    // random phases
    rq = '0;
    for (int ph = 0; ph < 6; ph++) begin
      rr = (ph != 0) && (ph != 3);
      dmode = 2'(ph % 4);
      dmst = 3'($urandom % 6);
      prio = 12'($urandom);
      tag = rr ? "R3 R7 R8 random" : "R2 R7 R8 random";
      for (int c = 0; c < 1500; c++) begin
        if ($urandom % 4 == 0) rq = 6'($urandom);
        if ($urandom % 64 == 0) lim = 8'($urandom % 5);
        cyc(rq, ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 5) == 0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule